// File: doc/BRIEF.md
# PCM time-slot assignment controller

This block places one 8-bit voice channel into a chosen time-slot of a serial PCM frame. Transmit and receive are handled separately. Both share one bit clock, `clk`, and each direction has its own one-cycle frame-sync pulse. The first bit of time-slot 0 falls in the clock cycle after the sync pulse is sampled. A frame has 64 slots of 8 bits each.

Each direction has a slot counter. A comparator checks it against the assigned slot number. During the matched slot the block does one of two things:

- On transmit, it drives a one-hot output-enable for one of two PCM ports and shifts the outgoing byte MSB first.
- On receive, it raises a one-hot capture strobe for one of two PCM inputs, shifts in the arriving bits and presents the byte with a valid pulse.

Assignments arrive as two-byte instructions on a serial control port framed by chip select. A new assignment is held in a pending register. It only takes effect at the start of the second frame after chip select rises at the end of the second byte.

The control parser has two states:

- `P_CMD` waits for a command byte. A valid command moves it to `P_DATA`.
- `P_DATA` returns to `P_CMD` at the next chip-select rise. If that byte is well formed, it commits the byte to the chosen direction.

Each direction has two further state machines:

- The slot counter has states `C_IDLE` and `C_RUN`. A sync pulse moves it from `C_IDLE` to `C_RUN`. A sync pulse while in `C_RUN` restarts the frame. After the last bit of slot 63 it goes from `C_RUN` back to `C_IDLE`.
- The activation tracker has states `A_IDLE`, `A_WAIT1` and `A_WAIT2`.
  - A commit moves it from any state to `A_WAIT1`.
  - A sync pulse moves it from `A_WAIT1` to `A_WAIT2`.
  - A sync pulse in `A_WAIT2` loads the pending setting and returns it to `A_IDLE`.

Top module: `pcm_slot_ctrl`

## Requirements
- R1: After reset both directions are disabled: `tx_oe` is 0, `rx_cap` is 0 and `rx_valid` is 0 until an assignment becomes active.
- R2: A frame is 64 slots of 8 bits. Bit k of slot s falls in the (8s+k+1)-th clock cycle after the cycle in which the frame sync is sampled high. After the last bit of slot 63 the direction stays inactive until the next sync.
- R3: A committed assignment takes effect at the second sync pulse of its direction after the commit. The first frame after the commit still uses the old setting. A further commit before activation replaces the pending value and restarts the two-frame wait.
- R4: During the 8 cycles of the assigned transmit slot, `tx_oe` is 2'b01 when port select is 0 and 2'b10 when it is 1. At all other times it is 0.
- R5: During the 8 cycles of the assigned receive slot, `rx_cap` is 2'b01 for port 0 and 2'b10 for port 1. At all other times it is 0.
- R6: With enable bit 7 of the assignment byte at 0, the direction drives no `tx_oe`, raises no `rx_cap` and produces no `rx_valid`.
- R7: In bit k (0 to 7) of the assigned transmit slot, `tx_dat` equals `tx_byte[7-k]`, so the byte goes out MSB first. Outside the slot `tx_dat` is 0.
- R8: Receive bits are sampled from `rx_din[port]`, MSB first. The cycle after the last bit, `rx_valid` is high for one cycle and `rx_byte` holds the 8 sampled bits.
- R9: A sync pulse that arrives before slot 63 completes restarts that direction at slot 0, bit 0.
- R10: An instruction is two bytes. Each byte is sent in its own chip-select-low window with exactly 8 shift strobes, MSB first. Byte 1 is 8'h01 for transmit or 8'h02 for receive. In byte 2, bit 7 is enable, bit 6 is port select and bits 5:0 are the slot number. A byte with another bit count, or an unknown command, is discarded and changes nothing.
- R11: Transmit and receive assignments, counters and sync inputs are independent. Writing one direction does not alter the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCM bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_cs_n | input | 1 | Control chip select, active low; one window per byte |
| ctl_shift | input | 1 | Control bit strobe, one bit per high cycle |
| ctl_sdi | input | 1 | Control serial data, MSB first |
| tx_fs | input | 1 | Transmit frame sync, one-cycle pulse |
| rx_fs | input | 1 | Receive frame sync, one-cycle pulse |
| tx_byte | input | 8 | Byte to transmit in the assigned slot |
| tx_dat | output | 1 | Transmit serial bit |
| tx_oe | output | 2 | Per-port transmit output enable |
| rx_din | input | 2 | Receive serial inputs, port 0 and port 1 |
| rx_cap | output | 2 | Per-port receive capture strobe |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse when rx_byte is updated |

## Verification
The bench goes after the following corner cases:

- **Frame just after a commit.** A design that loads a new assignment at the first sync would enable the slot one frame early.
- **Commit while another is pending.** A design that does not restart the wait would switch to the new setting one frame too soon.
- **Slot 63.** An off-by-one in the counter would lose or shift the last slot's byte.
- **Short frames.** A counter that ignores an early sync would drift past the assigned slot.
- **Malformed control bytes.** Bytes with the wrong bit count or an unknown command must be dropped. A lax parser would corrupt the active setting.

A cycle-level model checks the following on every clock:

- port steering through bit 6;
- enable gating through bit 7;
- the MSB-first bit order in both directions.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;

    localparam logic [7:0] CMD_TX = 8'h01;
    localparam logic [7:0] CMD_RX = 8'h02;

    typedef struct packed {
        logic       en;
        logic       ps;
        logic [5:0] slot;
    } slot_cfg_t;

    typedef enum logic {P_CMD, P_DATA} parse_state_t;
    typedef enum logic {C_IDLE, C_RUN} cnt_state_t;
    typedef enum logic [1:0] {A_IDLE, A_WAIT1, A_WAIT2} act_state_t;

endpackage

// File: rtl/pcm_ctl_parser.sv
module pcm_ctl_parser
    import pcm_slot_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       shift,
    input  logic       sdi,
    output logic [1:0] wr,
    output logic [7:0] wr_byte
);

    parse_state_t st, st_nx;
    logic         dir_q, dir_nx;
    logic         cs_q;
    logic [3:0]   bit_cnt;
    logic [7:0]   sh;
    logic [1:0]   wr_nx;
    logic         cs_rise, byte_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= P_CMD;
            dir_q <= 1'b0;
        end else begin
            st    <= st_nx;
            dir_q <= dir_nx;
        end
    end

    always_comb begin
        cs_rise = cs_n && !cs_q;
        byte_ok = (bit_cnt == 4'd8);
        st_nx   = st;
        dir_nx  = dir_q;
        wr_nx   = 2'b00;
        unique case (st)
            P_CMD: begin
                if (cs_rise && byte_ok && sh == CMD_TX) begin
                    st_nx  = P_DATA;
                    dir_nx = 1'b0;
                end else if (cs_rise && byte_ok && sh == CMD_RX) begin
                    st_nx  = P_DATA;
                    dir_nx = 1'b1;
                end
            end
            P_DATA: begin
                if (cs_rise) begin
                    st_nx = P_CMD;
                    if (byte_ok) wr_nx[dir_q] = 1'b1;
                end
            end
            default: st_nx = P_CMD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q    <= 1'b1;
            bit_cnt <= 4'd0;
            sh      <= 8'd0;
            wr      <= 2'b00;
            wr_byte <= 8'd0;
        end else begin
            cs_q <= cs_n;
            wr   <= wr_nx;
            if (wr_nx != 2'b00) wr_byte <= sh;
            if (cs_n) begin
                bit_cnt <= 4'd0;
            end else if (shift) begin
                sh <= {sh[6:0], sdi};
                if (bit_cnt != 4'd9) bit_cnt <= bit_cnt + 4'd1;
            end
        end
    end

    // R10: at most one direction is written per commit
    a_r10_one_dir: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr));

    // R10: a commit only follows a chip-select rise
    a_r10_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (wr != 2'b00) |-> ($past(cs_n) && !$past(cs_q)));

endmodule

// File: rtl/pcm_dir_slot.sv
module pcm_dir_slot
    import pcm_slot_pkg::*;
#(
    parameter int SLOTS     = 64,
    parameter int BITS      = 8,
    parameter bit DUAL_PORT = 1'b1,
    localparam int BW       = $clog2(BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fs,
    input  logic          wr,
    input  logic [7:0]    wr_byte,
    output logic          match,
    output logic          port,
    output logic [BW-1:0] bit_idx,
    output logic          last_bit
);

    localparam logic [5:0]    LAST_SLOT = 6'(SLOTS - 1);
    localparam logic [BW-1:0] LAST_BIT  = BW'(BITS - 1);

    cnt_state_t    cst, cst_nx;
    act_state_t    ast, ast_nx;
    slot_cfg_t     act_cfg, pend_cfg;
    logic [5:0]    slot_cnt;
    logic [BW-1:0] bit_cnt;
    logic          end_of_frame, load_act;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cst <= C_IDLE;
            ast <= A_IDLE;
        end else begin
            cst <= cst_nx;
            ast <= ast_nx;
        end
    end

    always_comb begin
        end_of_frame = (slot_cnt == LAST_SLOT) && (bit_cnt == LAST_BIT);
        unique case (cst)
            C_IDLE:  cst_nx = fs ? C_RUN : C_IDLE;
            C_RUN:   cst_nx = (!fs && end_of_frame) ? C_IDLE : C_RUN;
            default: cst_nx = C_IDLE;
        endcase
        load_act = 1'b0;
        unique case (ast)
            A_IDLE:  ast_nx = wr ? A_WAIT1 : A_IDLE;
            A_WAIT1: ast_nx = wr ? A_WAIT1 : (fs ? A_WAIT2 : A_WAIT1);
            A_WAIT2: begin
                ast_nx   = wr ? A_WAIT1 : (fs ? A_IDLE : A_WAIT2);
                load_act = fs && !wr;
            end
            default: ast_nx = A_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_cnt <= 6'd0;
            bit_cnt  <= '0;
            act_cfg  <= '0;
            pend_cfg <= '0;
        end else begin
            if (fs) begin
                slot_cnt <= 6'd0;
                bit_cnt  <= '0;
            end else if (cst == C_RUN) begin
                if (bit_cnt == LAST_BIT) begin
                    bit_cnt  <= '0;
                    slot_cnt <= slot_cnt + 6'd1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
            if (wr)       pend_cfg <= slot_cfg_t'(wr_byte);
            if (load_act) act_cfg  <= pend_cfg;
        end
    end

    always_comb begin
        match    = (cst == C_RUN) && act_cfg.en && (act_cfg.slot == slot_cnt);
        bit_idx  = bit_cnt;
        last_bit = (bit_cnt == LAST_BIT);
    end

    generate
        if (DUAL_PORT) begin : g_dual
            assign port = act_cfg.ps;
        end else begin : g_single
            assign port = 1'b0;
        end
    endgenerate

    // R9: a sync pulse starts slot 0 bit 0 on the next cycle
    a_r9_fs_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        fs |=> (cst == C_RUN && slot_cnt == 6'd0 && bit_cnt == '0));

    // R3: a commit never changes the active setting at once
    a_r3_wr_defers: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> $stable(act_cfg));

    // R3: the active setting only changes at a sync pulse
    a_r3_load_on_sync: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_cfg) |-> $past(fs));

    // R2: the direction goes idle after the last bit of the last slot
    a_r2_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (cst == C_RUN && end_of_frame && !fs) |=> (cst == C_IDLE && !match));

endmodule

// File: rtl/pcm_slot_ctrl.sv
module pcm_slot_ctrl
    import pcm_slot_pkg::*;
#(
    parameter int SLOTS     = 64,
    parameter int BITS      = 8,
    parameter bit DUAL_PORT = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctl_cs_n,
    input  logic            ctl_shift,
    input  logic            ctl_sdi,
    input  logic            tx_fs,
    input  logic            rx_fs,
    input  logic [BITS-1:0] tx_byte,
    output logic            tx_dat,
    output logic [1:0]      tx_oe,
    input  logic [1:0]      rx_din,
    output logic [1:0]      rx_cap,
    output logic [BITS-1:0] rx_byte,
    output logic            rx_valid
);

    localparam int BW = $clog2(BITS);
    localparam int NDIR = 2;

    logic [NDIR-1:0] fs_v, wr_v, match_v, port_v, last_v;
    logic [BW-1:0]   bidx_v [NDIR];
    logic [7:0]      wr_byte;
    logic [BITS-1:0] rx_sh;
    logic            rx_bit;

    assign fs_v = {rx_fs, tx_fs};

    pcm_ctl_parser u_parser (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (ctl_cs_n),
        .shift   (ctl_shift),
        .sdi     (ctl_sdi),
        .wr      (wr_v),
        .wr_byte (wr_byte)
    );

    generate
        for (genvar d = 0; d < NDIR; d++) begin : g_dir
            pcm_dir_slot #(
                .SLOTS     (SLOTS),
                .BITS      (BITS),
                .DUAL_PORT (DUAL_PORT)
            ) u_dir (
                .clk      (clk),
                .rst_n    (rst_n),
                .fs       (fs_v[d]),
                .wr       (wr_v[d]),
                .wr_byte  (wr_byte),
                .match    (match_v[d]),
                .port     (port_v[d]),
                .bit_idx  (bidx_v[d]),
                .last_bit (last_v[d])
            );
        end
    endgenerate

    always_comb begin
        tx_oe  = match_v[0] ? (port_v[0] ? 2'b10 : 2'b01) : 2'b00;
        tx_dat = match_v[0] ? tx_byte[BW'(BITS - 1) - bidx_v[0]] : 1'b0;
        rx_cap = match_v[1] ? (port_v[1] ? 2'b10 : 2'b01) : 2'b00;
        rx_bit = rx_din[port_v[1]];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sh    <= '0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (match_v[1]) begin
                rx_sh <= {rx_sh[BITS-2:0], rx_bit};
                if (last_v[1]) begin
                    rx_byte  <= {rx_sh[BITS-2:0], rx_bit};
                    rx_valid <= 1'b1;
                end
            end
        end
    end

    // R4: one transmit port at most
    a_r4_oe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tx_oe));

    // R5: one receive port at most
    a_r5_cap_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rx_cap));

    // R8: a valid byte always follows a capture cycle
    a_r8_valid_after_cap: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ($past(rx_cap) != 2'b00));

    // R7: no transmit data outside the slot
    a_r7_quiet_line: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_oe == 2'b00) |-> !tx_dat);

endmodule

// File: tb/pcm_slot_ctrl_tb_top.sv
module pcm_slot_ctrl_tb_top;

    localparam int CLK_P = 10;
    localparam int FRAME = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_cs_n = 1'b1, ctl_shift = 1'b0, ctl_sdi = 1'b0;
    logic       tx_fs = 1'b0, rx_fs = 1'b0;
    logic [7:0] tx_byte = 8'h5A;
    logic [1:0] rx_din = 2'b00;
    logic       tx_dat, rx_valid;
    logic [1:0] tx_oe, rx_cap;
    logic [7:0] rx_byte;

    always #(CLK_P/2) clk = ~clk;

    pcm_slot_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_cs_n(ctl_cs_n), .ctl_shift(ctl_shift),
        .ctl_sdi(ctl_sdi), .tx_fs(tx_fs), .rx_fs(rx_fs), .tx_byte(tx_byte),
        .tx_dat(tx_dat), .tx_oe(tx_oe), .rx_din(rx_din), .rx_cap(rx_cap),
        .rx_byte(rx_byte), .rx_valid(rx_valid)
    );

    // behavioural reference model
    int         mslot [2], mbit [2], ast [2];
    bit         mrun [2];
    logic [7:0] act [2], pend [2];
    logic [1:0] wrq;
    logic [7:0] wbq, msh, rsh, exp_rxb;
    int         mcnt, pst, pdir;
    bit         csp, exp_rxv;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int d = 0; d < 2; d++) begin
                mslot[d] = 0; mbit[d] = 0; ast[d] = 0; mrun[d] = 0;
                act[d] = 8'h00; pend[d] = 8'h00;
            end
            wrq = 2'b00; wbq = 8'h00; msh = 8'h00; rsh = 8'h00;
            exp_rxb = 8'h00; exp_rxv = 0; mcnt = 0; pst = 0; pdir = 0; csp = 1;
        end else begin
            logic [1:0] nwr;
            logic [7:0] nwb;
            bit         fsd;
            exp_rxv = 0;
            if (mrun[1] && act[1][7] && mslot[1] == int'(act[1][5:0])) begin
                rsh = {rsh[6:0], rx_din[act[1][6]]};
                if (mbit[1] == 7) begin exp_rxv = 1; exp_rxb = rsh; end
            end
            for (int d = 0; d < 2; d++) begin
                fsd = (d == 0) ? tx_fs : rx_fs;
                if (wrq[d]) begin pend[d] = wbq; ast[d] = 1; end
                else if (fsd && ast[d] == 1) ast[d] = 2;
                else if (fsd && ast[d] == 2) begin act[d] = pend[d]; ast[d] = 0; end
                if (fsd) begin mrun[d] = 1; mslot[d] = 0; mbit[d] = 0; end
                else if (mrun[d]) begin
                    if (mbit[d] == 7) begin
                        mbit[d] = 0;
                        if (mslot[d] == 63) begin mrun[d] = 0; mslot[d] = 0; end
                        else mslot[d] = mslot[d] + 1;
                    end else mbit[d] = mbit[d] + 1;
                end
            end
            nwr = 2'b00; nwb = wbq;
            if (ctl_cs_n && !csp) begin
                if (pst == 0 && mcnt == 8 && msh == 8'h01) begin pst = 1; pdir = 0; end
                else if (pst == 0 && mcnt == 8 && msh == 8'h02) begin pst = 1; pdir = 1; end
                else if (pst == 1) begin
                    if (mcnt == 8) begin nwr[pdir] = 1'b1; nwb = msh; end
                    pst = 0;
                end
            end
            if (ctl_cs_n) mcnt = 0;
            else if (ctl_shift) begin
                msh = {msh[6:0], ctl_sdi};
                if (mcnt != 9) mcnt = mcnt + 1;
            end
            csp = ctl_cs_n; wrq = nwr; wbq = nwb;
        end
    end

    // per-clock comparison and counters
    int m_checks = 0, m_errs = 0;
    int oe_p0 = 0, oe_p1 = 0, cap_p0 = 0, cap_p1 = 0, rxv_n = 0;

    always @(posedge clk) begin
        logic [1:0] eoe, ecap;
        #(CLK_P/4);
        if (rst_n) begin
            eoe  = (mrun[0] && act[0][7] && mslot[0] == int'(act[0][5:0])) ?
                   (act[0][6] ? 2'b10 : 2'b01) : 2'b00;
            ecap = (mrun[1] && act[1][7] && mslot[1] == int'(act[1][5:0])) ?
                   (act[1][6] ? 2'b10 : 2'b01) : 2'b00;
            m_checks++;
            if (tx_oe !== eoe) begin m_errs++;
                $display("FAIL R4 tx_oe act=%b exp=%b t=%0t", tx_oe, eoe, $time); end
            m_checks++;
            if (tx_dat !== ((eoe != 0) ? tx_byte[7 - mbit[0]] : 1'b0)) begin m_errs++;
                $display("FAIL R7 tx_dat act=%b exp=%b t=%0t", tx_dat,
                         (eoe != 0) ? tx_byte[7 - mbit[0]] : 1'b0, $time); end
            m_checks++;
            if (rx_cap !== ecap) begin m_errs++;
                $display("FAIL R5 rx_cap act=%b exp=%b t=%0t", rx_cap, ecap, $time); end
            m_checks++;
            if (rx_valid !== exp_rxv || (exp_rxv && rx_byte !== exp_rxb)) begin m_errs++;
                $display("FAIL R8 rx_valid/byte act=%b/%h exp=%b/%h t=%0t",
                         rx_valid, rx_byte, exp_rxv, exp_rxb, $time); end
            oe_p0  += (tx_oe == 2'b01);
            oe_p1  += (tx_oe == 2'b10);
            cap_p0 += (rx_cap == 2'b01);
            cap_p1 += (rx_cap == 2'b10);
            rxv_n  += rx_valid;
        end
    end

    int d_checks = 0, d_errs = 0;
    logic [7:0] lfsr = 8'hA7;

    task automatic chk(input string req, input int actv, input int expv);
        d_checks++;
        if (actv != expv) begin
            d_errs++;
            $display("FAIL %s act=%0d exp=%0d", req, actv, expv);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input int n);
        @(negedge clk) ctl_cs_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ctl_shift = 1'b1; ctl_sdi = b[7 - i];
        end
        @(negedge clk) ctl_shift = 1'b0;
        @(negedge clk) ctl_cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic wr_instr(input logic [7:0] cmd, input logic [7:0] dat, input int nb);
        send_byte(cmd, 8);
        send_byte(dat, nb);
        repeat (4) @(negedge clk);
    endtask

    int s_oe0, s_oe1, s_cp0, s_cp1, s_rxv;

    task automatic frame(input int len);
        for (int i = 0; i < len + 2; i++) begin
            @(negedge clk);
            tx_fs = (i == 0);
            rx_fs = (i == 0);
            if (i == 0) tx_byte = tx_byte + 8'h35;
            rx_din = lfsr[1:0];
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        end
    endtask

    task automatic snap();
        s_oe0 = oe_p0; s_oe1 = oe_p1; s_cp0 = cap_p0; s_cp1 = cap_p1; s_rxv = rxv_n;
    endtask

    bit timeout = 0;

    task automatic run_all();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 tx_oe at reset", int'(tx_oe), 0);
        chk("R1 rx_cap at reset", int'(rx_cap), 0);
        chk("R1 rx_valid at reset", int'(rx_valid), 0);

        // tx: enable, port 1, slot 3
        wr_instr(8'h01, 8'hC3, 8);
        snap(); frame(FRAME);
        chk("R3 tx first frame still off", (oe_p0 - s_oe0) + (oe_p1 - s_oe1), 0);
        snap(); frame(FRAME);
        chk("R4 tx port1 slot3 cycles", oe_p1 - s_oe1, 8);

        // rx: enable, port 0, slot 63
        wr_instr(8'h02, 8'hBF, 8);
        snap(); frame(FRAME);
        chk("R3 rx first frame no byte", rxv_n - s_rxv, 0);
        chk("R11 tx unchanged by rx write", oe_p1 - s_oe1, 8);
        snap(); frame(FRAME);
        chk("R2 rx slot63 byte count", rxv_n - s_rxv, 1);
        chk("R5 rx port0 cycles", cap_p0 - s_cp0, 8);

        // tx: enable, port 0, slot 0
        wr_instr(8'h01, 8'h80, 8);
        snap(); frame(FRAME);
        chk("R3 old tx setting kept", oe_p1 - s_oe1, 8);
        snap(); frame(FRAME);
        chk("R4 tx port0 slot0 cycles", oe_p0 - s_oe0, 8);

        // malformed: short data byte, unknown command
        wr_instr(8'h01, 8'h49, 7);
        wr_instr(8'h55, 8'h49, 8);
        snap(); frame(FRAME); frame(FRAME);
        chk("R10 malformed ignored", oe_p0 - s_oe0, 16);

        // disable tx
        wr_instr(8'h01, 8'h49, 8);
        snap(); frame(FRAME);
        chk("R6 tx on before disable", oe_p0 - s_oe0, 8);
        snap(); frame(FRAME);
        chk("R6 tx disabled", (oe_p0 - s_oe0) + (oe_p1 - s_oe1), 0);

        // rx: enable, port 1, slot 2, then short frames
        wr_instr(8'h02, 8'hC2, 8);
        frame(FRAME);
        snap(); frame(FRAME);
        chk("R5 rx port1 cycles", cap_p1 - s_cp1, 8);
        for (int k = 0; k < 3; k++) begin
            snap(); frame(30);
            chk("R9 short frame byte", rxv_n - s_rxv, 1);
        end

        // pending replaced before activation
        wr_instr(8'h01, 8'hC5, 8);
        frame(FRAME);
        wr_instr(8'h01, 8'h87, 8);
        snap(); frame(FRAME);
        chk("R3 rewrite restarts wait", (oe_p0 - s_oe0) + (oe_p1 - s_oe1), 0);
        snap(); frame(FRAME);
        chk("R3 latest value active", oe_p0 - s_oe0, 8);
        chk("R3 replaced value unused", oe_p1 - s_oe1, 0);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        fork
            run_all();
            begin repeat (200000) @(posedge clk); timeout = 1; end
        join_any
        disable fork;
        if (timeout) begin
            d_errs++; d_checks++;
            $display("FAIL watchdog act=expired exp=done");
        end
        $display("Result: errors=%0d of %0d checks", m_errs + d_errs, m_checks + d_checks);
        $finish;
    end

endmodule